// File: doc/BRIEF.md
# System Control Register Unit

This unit sits on a processor's coprocessor port as a slave and serves the system control register space. Each cycle it may receive one decoded transfer command. The command gives its kind, the privilege state of the core, a 3-bit opcode1 field, a 4-bit primary register number, a 4-bit secondary register field, a 3-bit subcode, the number of the core register involved, and the write data.

The unit answers a valid read with one cycle of `rsp_valid` and the data. A valid write updates the control register. It raises a one-cycle `undef_strobe` when the command must become an undefined-instruction trap. It raises a one-cycle `invalid_strobe` when the command is well-formed but not allowed. All responses appear on the clock edge that follows the command.

Primary register 0 is a read-only identification bank indexed by the subcode. Primary register 1 is the control word, and its endianness bit drives the load/store path.

Top module: `sysctl_regif`

## Requirements
- R1: Command kinds are encoded 0 = register write, 1 = register read, 2 = data operation, 3 = memory transfer. Kinds 2 and 3 raise `undef_strobe` one cycle after the command, whatever the other fields hold.
- R2: A command with `cmd_priv` low raises `undef_strobe` and performs no access. Undefined takes precedence over every invalid condition.
- R3: A read or write with a nonzero opcode1 field raises `invalid_strobe`.
- R4: A read or write that names core register 15 raises `invalid_strobe`.
- R5: A read of register 0 returns the ID word chosen by the subcode. With the default parameters these words are: subcode 0 gives 0x5A01B3C4 (main ID), subcode 1 gives 0x1D152152, and subcode 2 gives 0xC0DE0002. Each implemented optional word differs from the main ID.
- R6: A read of register 0 with a subcode that has no implemented word (3 to 7 by default) returns the main ID.
- R7: A write to register 0 is invalid. A register 0 access with a nonzero secondary field is invalid.
- R8: A register 1 access with a nonzero secondary field or a nonzero subcode is invalid.
- R9: An accepted write to register 1 stores the data. Bit 7 of the stored word drives `big_endian` (1 = big-endian) from the next cycle on.
- R10: Reset loads the control word with 0x00000070, so `big_endian` is 0. Bits 31:8 are reserved: they always read as 0 and writes to them are dropped.
- R11: An undefined or invalid command leaves the control word unchanged. Each strobe lasts one cycle. An accepted read gives exactly one cycle of `rsp_valid`, and an idle cycle gives no response.
- R12: Any access to primary registers 2 to 15 is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_kind | input | 2 | Command kind (see R1) |
| cmd_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| cmd_op1 | input | 3 | opcode1 field |
| cmd_crn | input | 4 | Primary register number |
| cmd_crm | input | 4 | Secondary register field |
| cmd_sub | input | 3 | Subcode |
| cmd_rd | input | 4 | Core register number |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| undef_strobe | output | 1 | Undefined-instruction indication |
| invalid_strobe | output | 1 | Invalid-command indication |
| big_endian | output | 1 | Endianness to the load/store path |

## Verification
The assertions assume the command fields are stable and defined in any cycle where `cmd_valid` is high. They also assume commands arrive at most one per cycle, with no stall or back-pressure from the core. The bench changes inputs only on falling edges, and it drops `cmd_valid` for one idle cycle after each command. Every strobe and response is therefore seen both in its own cycle and in the quiet cycle that follows, which is where the one-cycle width and the unchanged state are checked.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 32;
    localparam int REG_W  = 4;
    localparam int SUB_W  = 3;
    localparam int OP1_W  = 3;
    localparam int NUM_SUB = 1 << SUB_W;
    localparam logic [REG_W-1:0] PC_REG = 4'd15;

    typedef enum logic [1:0] {
        K_WRITE = 2'd0,
        K_READ  = 2'd1,
        K_DATA  = 2'd2,
        K_MEM   = 2'd3
    } cmd_kind_e;

    typedef enum logic [REG_W-1:0] {
        P_IDENT = 4'd0,
        P_CTRL  = 4'd1
    } prim_reg_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic               priv;
        logic [OP1_W-1:0]   op1;
        logic [REG_W-1:0]   crn;
        logic [REG_W-1:0]   crm;
        logic [SUB_W-1:0]   sub;
        logic [REG_W-1:0]   rd;
    } cmd_t;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic undef;
        logic invalid;
    } verdict_t;

    function automatic logic is_transfer(input cmd_kind_e k);
        return (k == K_WRITE) || (k == K_READ);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic     valid,
    input  cmd_t     cmd,
    output verdict_t verdict
);

    logic reg_bad;
    logic undef_c;
    logic invalid_c;

    always_comb begin
        case (cmd.crn)
            P_IDENT: reg_bad = (cmd.kind == K_WRITE) || (cmd.crm != '0);
            P_CTRL:  reg_bad = (cmd.crm != '0) || (cmd.sub != '0);
            default: reg_bad = 1'b1;
        endcase
    end

    assign undef_c   = valid && (!is_transfer(cmd.kind) || !cmd.priv);
    assign invalid_c = valid && !undef_c &&
                       ((cmd.op1 != '0) || (cmd.rd == PC_REG) || reg_bad);

    always_comb begin
        verdict.undef   = undef_c;
        verdict.invalid = invalid_c;
        verdict.rd_ok   = valid && !undef_c && !invalid_c && (cmd.kind == K_READ);
        verdict.wr_ok   = valid && !undef_c && !invalid_c && (cmd.kind == K_WRITE);
    end

endmodule

// File: rtl/sysctl_id_bank.sv
module sysctl_id_bank
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0]              MAIN_ID   = 32'h5A01_B3C4,
    parameter logic [NUM_SUB-1:0]             IMPL_MASK = 8'b0000_0111,
    parameter logic [NUM_SUB-1:0][DATA_W-1:0] OPT_IDS   = {
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'hC0DE_0002, 32'h1D15_2152, 32'h0 }
) (
    input  logic [SUB_W-1:0]  sub,
    output logic [DATA_W-1:0] id_word
);

    logic [DATA_W-1:0] table_w [NUM_SUB];

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_slot
        if (s == 0) begin : g_main
            assign table_w[s] = MAIN_ID;
        end else begin : g_opt
            assign table_w[s] = IMPL_MASK[s] ? OPT_IDS[s] : MAIN_ID;
        end
    end

    assign id_word = table_w[sub];

endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL  = 32'h0000_0070,
    parameter logic [DATA_W-1:0] WMASK      = 32'h0000_00FF,
    parameter int                ENDIAN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              big_endian
);

    localparam logic [DATA_W-1:0] RESET_MASKED = RESET_VAL & WMASK;

    logic [DATA_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= RESET_MASKED;
        end else if (wr_en) begin
            value_q <= wdata & WMASK;
        end
    end

    assign value      = value_q;
    assign big_endian = value_q[ENDIAN_BIT];

endmodule

// File: rtl/sysctl_regif.sv
module sysctl_regif
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0]              MAIN_ID   = 32'h5A01_B3C4,
    parameter logic [NUM_SUB-1:0]             IMPL_MASK = 8'b0000_0111,
    parameter logic [NUM_SUB-1:0][DATA_W-1:0] OPT_IDS   = {
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'hC0DE_0002, 32'h1D15_2152, 32'h0 },
    parameter logic [DATA_W-1:0]              CTRL_RESET = 32'h0000_0070,
    parameter logic [DATA_W-1:0]              CTRL_WMASK = 32'h0000_00FF,
    parameter int                             ENDIAN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic              cmd_priv,
    input  logic [OP1_W-1:0]  cmd_op1,
    input  logic [REG_W-1:0]  cmd_crn,
    input  logic [REG_W-1:0]  cmd_crm,
    input  logic [SUB_W-1:0]  cmd_sub,
    input  logic [REG_W-1:0]  cmd_rd,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              undef_strobe,
    output logic              invalid_strobe,
    output logic              big_endian
);

    cmd_t              cmd;
    verdict_t          verdict;
    logic [DATA_W-1:0] id_word;
    logic [DATA_W-1:0] ctrl_value;
    logic [DATA_W-1:0] read_mux;

    always_comb begin
        cmd.kind = cmd_kind_e'(cmd_kind);
        cmd.priv = cmd_priv;
        cmd.op1  = cmd_op1;
        cmd.crn  = cmd_crn;
        cmd.crm  = cmd_crm;
        cmd.sub  = cmd_sub;
        cmd.rd   = cmd_rd;
    end

    sysctl_decode u_decode (
        .valid   (cmd_valid),
        .cmd     (cmd),
        .verdict (verdict)
    );

    sysctl_id_bank #(
        .MAIN_ID   (MAIN_ID),
        .IMPL_MASK (IMPL_MASK),
        .OPT_IDS   (OPT_IDS)
    ) u_id_bank (
        .sub     (cmd_sub),
        .id_word (id_word)
    );

    sysctl_ctrl_reg #(
        .RESET_VAL  (CTRL_RESET),
        .WMASK      (CTRL_WMASK),
        .ENDIAN_BIT (ENDIAN_BIT)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (verdict.wr_ok && (cmd_crn == P_CTRL)),
        .wdata      (cmd_wdata),
        .value      (ctrl_value),
        .big_endian (big_endian)
    );

    assign read_mux = (cmd_crn == P_IDENT) ? id_word : ctrl_value;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            undef_strobe   <= 1'b0;
            invalid_strobe <= 1'b0;
        end else begin
            rsp_valid      <= verdict.rd_ok;
            undef_strobe   <= verdict.undef;
            invalid_strobe <= verdict.invalid;
            if (verdict.rd_ok) begin
                rsp_rdata <= read_mux;
            end
        end
    end

endmodule

// File: rtl/sysctl_regif_chk.sv
module sysctl_regif_chk
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0]  MAIN_ID    = 32'h5A01_B3C4,
    parameter logic [NUM_SUB-1:0] IMPL_MASK  = 8'b0000_0111,
    parameter int                 ENDIAN_BIT = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic              cmd_priv,
    input logic [OP1_W-1:0]  cmd_op1,
    input logic [REG_W-1:0]  cmd_crn,
    input logic [REG_W-1:0]  cmd_crm,
    input logic [SUB_W-1:0]  cmd_sub,
    input logic [REG_W-1:0]  cmd_rd,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              undef_strobe,
    input logic              invalid_strobe,
    input logic              big_endian
);

    logic xfer_ok;
    logic id_read;
    logic ctrl_write;

    assign xfer_ok    = cmd_valid && cmd_priv && (cmd_kind <= 2'd1);
    assign id_read    = xfer_ok && (cmd_kind == 2'd1) && (cmd_op1 == '0) &&
                        (cmd_rd != 4'd15) && (cmd_crn == 4'd0) && (cmd_crm == '0);
    assign ctrl_write = xfer_ok && (cmd_kind == 2'd0) && (cmd_op1 == '0) &&
                        (cmd_rd != 4'd15) && (cmd_crn == 4'd1) &&
                        (cmd_crm == '0) && (cmd_sub == '0);

    a_r1_undef_kind: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind[1]) |=> (undef_strobe && !invalid_strobe));

    a_r2_user_undef: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_priv) |=> (undef_strobe && !rsp_valid && !invalid_strobe));

    a_r3_op1_invalid: assert property (@(posedge clk) disable iff (rst)
        (xfer_ok && cmd_op1 != '0) |=> invalid_strobe);

    a_r4_pc_invalid: assert property (@(posedge clk) disable iff (rst)
        (xfer_ok && cmd_rd == 4'd15) |=> invalid_strobe);

    a_r5_opt_differs: assert property (@(posedge clk) disable iff (rst)
        (id_read && cmd_sub != '0 && IMPL_MASK[cmd_sub]) |=> (rsp_valid && rsp_rdata != MAIN_ID));

    a_r6_fallback: assert property (@(posedge clk) disable iff (rst)
        (id_read && (cmd_sub == '0 || !IMPL_MASK[cmd_sub])) |=> (rsp_valid && rsp_rdata == MAIN_ID));

    a_r9_endian_follows: assert property (@(posedge clk) disable iff (rst)
        ctrl_write |=> (big_endian == $past(cmd_wdata[ENDIAN_BIT])));

    a_r11_state_kept: assert property (@(posedge clk) disable iff (rst)
        (undef_strobe || invalid_strobe) |-> $stable(big_endian));

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $countones({rsp_valid, undef_strobe, invalid_strobe}) <= 1);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!rsp_valid && !undef_strobe && !invalid_strobe));

    a_r12_other_regs: assert property (@(posedge clk) disable iff (rst)
        (xfer_ok && cmd_crn >= 4'd2) |=> invalid_strobe);

endmodule

bind sysctl_regif sysctl_regif_chk #(
    .MAIN_ID    (MAIN_ID),
    .IMPL_MASK  (IMPL_MASK),
    .ENDIAN_BIT (ENDIAN_BIT)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .cmd_kind       (cmd_kind),
    .cmd_priv       (cmd_priv),
    .cmd_op1        (cmd_op1),
    .cmd_crn        (cmd_crn),
    .cmd_crm        (cmd_crm),
    .cmd_sub        (cmd_sub),
    .cmd_rd         (cmd_rd),
    .cmd_wdata      (cmd_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .undef_strobe   (undef_strobe),
    .invalid_strobe (invalid_strobe),
    .big_endian     (big_endian)
);

// File: tb/sysctl_regif_bench.sv
module sysctl_regif_bench;

    localparam int NV = 21;
    localparam logic [31:0] MAIN = 32'h5A01_B3C4;

    typedef struct packed {
        logic [1:0]  kind;
        logic        priv;
        logic [2:0]  op1;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  sub;
        logic [3:0]  rd;
        logic [31:0] wdata;
        logic [1:0]  exp;      // 0 write ok, 1 read data, 2 undef, 3 invalid
        logic [31:0] exp_data;
        logic        exp_be;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 4'd2, 32'h0,         2'd1, MAIN,          1'b0, 8'd5},  // R5
        '{2'd1, 1'b1, 3'd0, 4'd0, 4'd0, 3'd1, 4'd3, 32'h0,         2'd1, 32'h1D15_2152, 1'b0, 8'd5},  // R5
        '{2'd1, 1'b1, 3'd0, 4'd0, 4'd0, 3'd2, 4'd0, 32'h0,         2'd1, 32'hC0DE_0002, 1'b0, 8'd5},  // R5
        '{2'd1, 1'b1, 3'd0, 4'd0, 4'd0, 3'd5, 4'd1, 32'h0,         2'd1, MAIN,          1'b0, 8'd6},  // R6
        '{2'd1, 1'b1, 3'd0, 4'd0, 4'd0, 3'd7, 4'd14, 32'h0,        2'd1, MAIN,          1'b0, 8'd6},  // R6
        '{2'd1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd4, 32'h0,         2'd1, 32'h0000_0070, 1'b0, 8'd10}, // R10
        '{2'd0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd5, 32'hFFFF_FF80, 2'd0, 32'h0,         1'b1, 8'd9},  // R9
        '{2'd1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd6, 32'h0,         2'd1, 32'h0000_0080, 1'b1, 8'd10}, // R10
        '{2'd0, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd7, 32'h0,         2'd2, 32'h0,         1'b1, 8'd2},  // R2
        '{2'd0, 1'b1, 3'd1, 4'd1, 4'd0, 3'd0, 4'd7, 32'h0,         2'd3, 32'h0,         1'b1, 8'd3},  // R3
        '{2'd0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd15, 32'h0,        2'd3, 32'h0,         1'b1, 8'd4},  // R4
        '{2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 4'd1, 32'h0,         2'd3, 32'h0,         1'b1, 8'd7},  // R7
        '{2'd1, 1'b1, 3'd0, 4'd0, 4'd1, 3'd0, 4'd1, 32'h0,         2'd3, 32'h0,         1'b1, 8'd7},  // R7
        '{2'd0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd1, 4'd1, 32'h0,         2'd3, 32'h0,         1'b1, 8'd8},  // R8
        '{2'd0, 1'b1, 3'd0, 4'd1, 4'd2, 3'd0, 4'd1, 32'h0,         2'd3, 32'h0,         1'b1, 8'd8},  // R8
        '{2'd2, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd1, 32'h0,         2'd2, 32'h0,         1'b1, 8'd1},  // R1
        '{2'd3, 1'b0, 3'd3, 4'd1, 4'd0, 3'd0, 4'd15, 32'h0,        2'd2, 32'h0,         1'b1, 8'd1},  // R1
        '{2'd1, 1'b1, 3'd0, 4'd5, 4'd0, 3'd0, 4'd1, 32'h0,         2'd3, 32'h0,         1'b1, 8'd12}, // R12
        '{2'd1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd2, 32'h0,         2'd1, 32'h0000_0080, 1'b1, 8'd11}, // R11
        '{2'd0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd2, 32'h0000_0045, 2'd0, 32'h0,         1'b0, 8'd9},  // R9
        '{2'd1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd3, 32'h0,         2'd1, 32'h0000_0045, 1'b0, 8'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic        cmd_priv = 1'b0;
    logic [2:0]  cmd_op1 = '0;
    logic [3:0]  cmd_crn = '0;
    logic [3:0]  cmd_crm = '0;
    logic [2:0]  cmd_sub = '0;
    logic [3:0]  cmd_rd = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        undef_strobe;
    logic        invalid_strobe;
    logic        big_endian;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sysctl_regif u_sysctl_regif (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_kind       (cmd_kind),
        .cmd_priv       (cmd_priv),
        .cmd_op1        (cmd_op1),
        .cmd_crn        (cmd_crn),
        .cmd_crm        (cmd_crm),
        .cmd_sub        (cmd_sub),
        .cmd_rd         (cmd_rd),
        .cmd_wdata      (cmd_wdata),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .undef_strobe   (undef_strobe),
        .invalid_strobe (invalid_strobe),
        .big_endian     (big_endian)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // outcome word: {rsp_valid, undef, invalid, big_endian}
    function automatic logic [3:0] outcome();
        return {rsp_valid, undef_strobe, invalid_strobe, big_endian};
    endfunction

    task automatic quiet_check(input string req, input logic be);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(req, {60'd0, outcome()}, {60'd0, 3'b000, be});
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 reset outputs", {60'd0, outcome()}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [3:0] exp_o;
            v = VECS[i];
            cmd_valid = 1'b1;
            cmd_kind  = v.kind;
            cmd_priv  = v.priv;
            cmd_op1   = v.op1;
            cmd_crn   = v.crn;
            cmd_crm   = v.crm;
            cmd_sub   = v.sub;
            cmd_rd    = v.rd;
            cmd_wdata = v.wdata;
            @(negedge clk);
            exp_o = {v.exp == 2'd1, v.exp == 2'd2, v.exp == 2'd3, v.exp_be};
            check($sformatf("R%0d vector %0d outcome", v.req, i), {60'd0, outcome()}, {60'd0, exp_o});
            if (v.exp == 2'd1)
                check($sformatf("R%0d vector %0d data", v.req, i), {32'd0, rsp_rdata}, {32'd0, v.exp_data});
            // R11: strobes and responses last exactly one cycle
            quiet_check("R11 one-cycle pulse", v.exp_be);
        end

        // R11: idle cycle with garbage fields produces nothing
        cmd_kind = 2'd3; cmd_priv = 1'b0; cmd_op1 = 3'd7; cmd_crn = 4'd9;
        cmd_wdata = 32'hFFFF_FFFF;
        quiet_check("R11 idle ignored", 1'b0);

        // R9 then R10: set big-endian, reset mid-run restores default
        cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_priv = 1'b1; cmd_op1 = '0;
        cmd_crn = 4'd1; cmd_crm = '0; cmd_sub = '0; cmd_rd = 4'd0;
        cmd_wdata = 32'h0000_0080;
        @(negedge clk);
        check("R9 endian set", {63'd0, big_endian}, 64'd1);
        cmd_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset clears endian", {60'd0, outcome()}, 64'd0);
        cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_rd = 4'd2;
        @(negedge clk);
        check("R10 reset value readback", {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, 32'h0000_0070});
        cmd_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule